// File: doc/BRIEF.md
# Auto-Retry Transmit Sequencer

The sequencer runs one outgoing frame transaction from start to a final result code. A start pulse captures a control byte. The block then asks an external channel-access engine for a clear channel and repeats that request while the channel stays busy. Once the channel is clear it fires the frame transmitter and waits for the receive side to report an acknowledgement or a timeout. A timeout leads to another attempt until the frame-retry budget runs out.

Two settings of the channel-access field change the flow. One bypasses channel assessment and transmits at once. The other is reserved and ends the transaction as an invalid configuration.

The same block also handles acknowledgement frames that must be sent on behalf of the receive path. With the slotted flag clear, such an acknowledgement goes out immediately. With it set, the block holds and reports a waiting status until a rising edge arrives on an asynchronous trigger input.

Top module: `rtx_sequencer`

## Requirements
- R1: The control byte is captured when a transaction or an acknowledgement request is accepted. Bits 7:4 hold the frame-retry limit, bits 3:1 hold the channel-access retry limit and bit 0 holds the slotted flag.
- R2: Each `ack_tmo` answer to a transmission starts a new attempt while the number of retries made is below the frame-retry limit, which can be 0 to 15. The frame transmitter is therefore started at most limit+1 times. Once the limit is used up, the transaction ends with result 5. The retry count is cleared only when a new transaction starts.
- R3: In each attempt, `cca_req` is issued at most limit+1 times, with the limit from 0 to 5. If every answer reports a busy channel, the transaction ends with result 3 and no further transmission. The channel-access retry count is cleared at every new attempt.
- R4: A channel-access field of 7 makes the block start the transmitter without ever raising `cca_req`.
- R5: A channel-access field of 6 ends the transaction with result 7. In that case neither `cca_req` nor `tx_start` is raised.
- R6: An `ack_rcvd` answer to a transmission ends the transaction with result 0.
- R7: With the slotted flag set, an acknowledgement request raises `wait_trig` and shows result 1 until a rising edge on `trig_in` is seen through a two-flop synchronizer. The block then pulses `ack_send` and finishes with result 0.
- R8: With the slotted flag clear, an acknowledgement request pulses `ack_send` one cycle after it is accepted, with no trigger needed.
- R9: Trigger edges that arrive while the block is not waiting for one cause no `ack_send`.
- R10: `busy` rises the cycle after an accepted start and stays high until the single-cycle `done` pulse. `result` carries the code during `done`, with 0 for success, 1 for waiting on the trigger, 3 for channel-access failure, 5 for no acknowledgement and 7 for an invalid setting.
- R11: After reset, `busy`, `done`, `cca_req`, `tx_start`, `ack_send` and `wait_trig` are low and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_byte | input | 8 | Frame-retry, channel-access-retry and slotted fields |
| start | input | 1 | Begin a transmit transaction |
| ack_req | input | 1 | Receive path asks for an acknowledgement to be sent |
| trig_in | input | 1 | Asynchronous trigger for slotted acknowledgement |
| cca_req | output | 1 | One-cycle request to the channel-access engine |
| cca_done | input | 1 | Channel-access engine answer strobe |
| cca_clear | input | 1 | Channel found clear, valid with `cca_done` |
| tx_start | output | 1 | One-cycle start for the frame transmitter |
| ack_rcvd | input | 1 | Acknowledgement received for the last frame |
| ack_tmo | input | 1 | Acknowledgement wait expired |
| ack_send | output | 1 | One-cycle command to send an acknowledgement frame |
| wait_trig | output | 1 | Waiting for the trigger edge |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end of transaction |
| result | output | 3 | Result code |

## Verification
A wrong retry counter shows at the ports as a change in the number of `cca_req` or `tx_start` pulses seen in one transaction, and the bench counts exactly those pulses. A counter that fails to clear between attempts cuts a transaction short with the wrong code. A stray synchronizer edge shows up as an `ack_send` with no waiting state. That shows within three cycles of the trigger. A stuck sequencing state shows as a `done` that never comes, or as `busy` still high one cycle after `done`.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
   typedef enum logic [2:0] {
      RES_OK      = 3'd0,
      RES_OK_WAIT = 3'd1,
      RES_CH_FAIL = 3'd3,
      RES_NO_ACK  = 3'd5,
      RES_BAD_CFG = 3'd7
   } rtx_res_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_CCA_REQ, ST_CCA_WAIT, ST_TX_REQ,
      ST_TX_WAIT, ST_TRIG_WAIT, ST_ACK_SEND, ST_FIN
   } rtx_state_e;
endpackage

// File: rtl/rtx_edge_sync.sv
module rtx_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rtx_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], din};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R9
endmodule

// File: rtl/rtx_limit_cnt.sv
module rtx_limit_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic         at_lim
);
   if (W < 1) begin : g_bad_width
      $error("rtx_limit_cnt: W must be positive");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

   assign at_lim = (cnt == limit);

   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |-> (cnt != '1)); // R2
endmodule

// File: rtl/rtx_sequencer.sv
module rtx_sequencer
   import rtx_pkg::*;
#(
   parameter int FR_W        = 4,
   parameter int CS_W        = 3,
   parameter int SYNC_STAGES = 2,
   localparam int CTRL_W     = FR_W + CS_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] ctrl_byte,
   input  logic              start,
   input  logic              ack_req,
   input  logic              trig_in,
   output logic              cca_req,
   input  logic              cca_done,
   input  logic              cca_clear,
   output logic              tx_start,
   input  logic              ack_rcvd,
   input  logic              ack_tmo,
   output logic              ack_send,
   output logic              wait_trig,
   output logic              busy,
   output logic              done,
   output logic [2:0]        result
);
   localparam logic [CS_W-1:0] CS_BYPASS   = '1;
   localparam logic [CS_W-1:0] CS_RESERVED = CS_BYPASS - 1'b1;

   if (CS_W != 3) begin : g_bad_cs
      $error("rtx_sequencer: channel-access field must be 3 bits");
   end
   if (FR_W < 1 || FR_W > 8) begin : g_bad_fr
      $error("rtx_sequencer: FR_W out of range");
   end

   rtx_state_e      state, state_n;
   logic [FR_W-1:0] fr_lim_q;
   logic [CS_W-1:0] cs_lim_q;
   logic            slot_q;
   rtx_res_e        res_q, res_n;
   logic            res_ld, cfg_ld;
   logic            fr_clr, fr_inc, fr_at_lim;
   logic            cs_clr, cs_inc, cs_at_lim;
   logic            trig_rise;

   wire [FR_W-1:0] in_fr   = ctrl_byte[CTRL_W-1 -: FR_W];
   wire [CS_W-1:0] in_cs   = ctrl_byte[CS_W:1];
   wire            in_slot = ctrl_byte[0];

   rtx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(trig_in), .rise(trig_rise));

   rtx_limit_cnt #(.W(FR_W)) u_fr_cnt (
      .clk(clk), .rst_n(rst_n), .clr(fr_clr), .inc(fr_inc),
      .limit(fr_lim_q), .at_lim(fr_at_lim));

   rtx_limit_cnt #(.W(CS_W)) u_cs_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cs_clr), .inc(cs_inc),
      .limit(cs_lim_q), .at_lim(cs_at_lim));

   always_comb begin
      state_n = state;
      res_n   = res_q;
      res_ld  = 1'b0;
      cfg_ld  = 1'b0;
      fr_clr  = 1'b0;
      fr_inc  = 1'b0;
      cs_clr  = 1'b0;
      cs_inc  = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (start) begin
               cfg_ld = 1'b1;
               fr_clr = 1'b1;
               cs_clr = 1'b1;
               if (in_cs == CS_RESERVED) begin
                  res_n = RES_BAD_CFG; res_ld = 1'b1; state_n = ST_FIN;
               end else if (in_cs == CS_BYPASS) begin
                  state_n = ST_TX_REQ;
               end else begin
                  state_n = ST_CCA_REQ;
               end
            end else if (ack_req) begin
               cfg_ld  = 1'b1;
               state_n = in_slot ? ST_TRIG_WAIT : ST_ACK_SEND;
            end
         end
         ST_CCA_REQ: state_n = ST_CCA_WAIT;
         ST_CCA_WAIT: begin
            if (cca_done) begin
               if (cca_clear) begin
                  state_n = ST_TX_REQ;
               end else if (cs_at_lim) begin
                  res_n = RES_CH_FAIL; res_ld = 1'b1; state_n = ST_FIN;
               end else begin
                  cs_inc = 1'b1; state_n = ST_CCA_REQ;
               end
            end
         end
         ST_TX_REQ: state_n = ST_TX_WAIT;
         ST_TX_WAIT: begin
            if (ack_rcvd) begin
               res_n = RES_OK; res_ld = 1'b1; state_n = ST_FIN;
            end else if (ack_tmo) begin
               if (fr_at_lim) begin
                  res_n = RES_NO_ACK; res_ld = 1'b1; state_n = ST_FIN;
               end else begin
                  fr_inc  = 1'b1;
                  cs_clr  = 1'b1;
                  state_n = (cs_lim_q == CS_BYPASS) ? ST_TX_REQ : ST_CCA_REQ;
               end
            end
         end
         ST_TRIG_WAIT: if (trig_rise) state_n = ST_ACK_SEND;
         ST_ACK_SEND: begin
            res_n = RES_OK; res_ld = 1'b1; state_n = ST_FIN;
         end
         ST_FIN:  state_n = ST_IDLE;
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         res_q    <= RES_OK;
         fr_lim_q <= '0;
         cs_lim_q <= '0;
         slot_q   <= 1'b0;
      end else begin
         state <= state_n;
         if (res_ld) res_q <= res_n;
         if (cfg_ld) begin
            fr_lim_q <= in_fr;
            cs_lim_q <= in_cs;
            slot_q   <= in_slot;
         end
      end
   end

   assign cca_req   = (state == ST_CCA_REQ);
   assign tx_start  = (state == ST_TX_REQ);
   assign ack_send  = (state == ST_ACK_SEND);
   assign wait_trig = (state == ST_TRIG_WAIT);
   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_FIN);
   assign result    = wait_trig ? RES_OK_WAIT : res_q;

   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy); // R10
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R10
   AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cca_req, tx_start, ack_send, done})); // R10
   AST_BYPASS_NO_CCA: assert property (@(posedge clk) disable iff (!rst_n)
      cca_req |-> (cs_lim_q != CS_BYPASS)); // R4
   AST_RESERVED_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
      (cca_req || tx_start) |-> (cs_lim_q != CS_RESERVED)); // R5
   AST_WAIT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      wait_trig |-> (result == RES_OK_WAIT)); // R7
   AST_SLOT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_send && slot_q) |-> $past(trig_rise)); // R7
endmodule

// File: tb/rtx_sequencer_test.sv
`timescale 1ns/1ps
module rtx_sequencer_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] ctrl_byte = '0;
   logic start = 0, ack_req = 0, trig_in = 0;
   logic cca_done = 0, cca_clear = 0, ack_rcvd = 0, ack_tmo = 0;
   logic cca_req, tx_start, ack_send, wait_trig, busy, done;
   logic [2:0] result;

   int checks = 0, errors = 0;
   int busy_per_att = 0, nack_limit = 0;
   int busy_seen = 0, nacks = 0, n_cca = 0, n_tx = 0, n_ack = 0;

   always #2 clk = ~clk;

   rtx_sequencer uut (
      .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte), .start(start),
      .ack_req(ack_req), .trig_in(trig_in), .cca_req(cca_req),
      .cca_done(cca_done), .cca_clear(cca_clear), .tx_start(tx_start),
      .ack_rcvd(ack_rcvd), .ack_tmo(ack_tmo), .ack_send(ack_send),
      .wait_trig(wait_trig), .busy(busy), .done(done), .result(result));

   // {ctrl, busy answers per attempt, timeouts before ack, exp result, exp tx, exp cca}
   localparam logic [47:0] VEC [10] = '{
      {8'h38, 8'd0, 8'd0,  8'd0, 8'd1,  8'd1},   // R6
      {8'h38, 8'd2, 8'd2,  8'd0, 8'd3,  8'd9},   // R3 counter cleared per attempt
      {8'h27, 8'd1, 8'd5,  8'd5, 8'd3,  8'd6},   // R2
      {8'h00, 8'd0, 8'd1,  8'd5, 8'd1,  8'd1},   // R2 zero retries
      {8'h14, 8'd3, 8'd0,  8'd3, 8'd0,  8'd3},   // R3
      {8'h5E, 8'd9, 8'd1,  8'd0, 8'd2,  8'd0},   // R4
      {8'h4C, 8'd0, 8'd0,  8'd7, 8'd0,  8'd0},   // R5
      {8'hFA, 8'd5, 8'd20, 8'd5, 8'd16, 8'd96},  // R1 R2 full limits
      {8'h0A, 8'd6, 8'd0,  8'd3, 8'd0,  8'd6},   // R3
      {8'h20, 8'd1, 8'd0,  8'd3, 8'd0,  8'd1}    // R3 zero limit
   };

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // channel-access engine and receive side model
   initial begin
      @(negedge clk);
      forever begin
         if (cca_req) begin
            n_cca++;
            @(negedge clk);
            cca_done  = 1'b1;
            cca_clear = (busy_seen >= busy_per_att);
            if (!cca_clear) busy_seen++;
            @(negedge clk);
            cca_done = 1'b0;
         end else if (tx_start) begin
            n_tx++;
            busy_seen = 0;
            @(negedge clk);
            if (nacks < nack_limit) begin ack_tmo = 1'b1; nacks++; end
            else ack_rcvd = 1'b1;
            @(negedge clk);
            ack_tmo = 1'b0; ack_rcvd = 1'b0;
         end else begin
            @(negedge clk);
         end
      end
   end

   initial forever begin
      @(negedge clk);
      if (ack_send) n_ack++;
   end

   initial begin
      repeat (50000) @(posedge clk);
      check("watchdog", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic wait_done(output int res, output int found);
      found = 0; res = -1;
      for (int k = 0; k < 3000; k++) begin
         if (done) begin found = 1; res = int'(result); break; end
         @(negedge clk);
      end
   endtask

   task automatic run_txn(input logic [7:0] c, input int b, input int n,
                          output int res);
      int found;
      busy_per_att = b; nack_limit = n;
      busy_seen = 0; nacks = 0; n_cca = 0; n_tx = 0;
      @(negedge clk);
      ctrl_byte = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R10 busy after start", int'(busy), 1);
      wait_done(res, found);
      check("R10 done reached", found, 1);
      check("R10 busy during done", int'(busy), 1);
      @(negedge clk);
      check("R10 done single cycle", int'(done), 0);
      check("R10 busy cleared", int'(busy), 0);
   endtask

   initial begin
      int res, found, seen;
      repeat (3) @(negedge clk);
      check("R11 busy", int'(busy), 0);
      check("R11 done", int'(done), 0);
      check("R11 strobes", int'({cca_req, tx_start, ack_send, wait_trig}), 0);
      check("R11 result", int'(result), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < 10; v++) begin
         logic [47:0] e;
         e = VEC[v];
         run_txn(e[47:40], int'(e[39:32]), int'(e[31:24]), res);
         case (e[23:16])
            8'd0: check("R6 result ok", res, 0);
            8'd3: check("R3 result channel fail", res, 3);
            8'd5: check("R2 result no ack", res, 5);
            default: check("R5 result invalid", res, int'(e[23:16]));
         endcase
         check("R2 transmit count", n_tx, int'(e[15:8]));
         check("R3 R4 access request count", n_cca, int'(e[7:0]));
      end

      // R9: trigger edges while idle
      n_ack = 0;
      trig_in = 1'b1; repeat (3) @(negedge clk);
      trig_in = 1'b0; repeat (5) @(negedge clk);
      check("R9 no ack send while idle", n_ack, 0);
      check("R9 idle stays idle", int'(busy), 0);

      // R9: trigger during a transmit transaction
      fork
         run_txn(8'h38, 1, 1, res);
         begin
            repeat (2) @(negedge clk);
            trig_in = 1'b1; repeat (2) @(negedge clk);
            trig_in = 1'b0;
         end
      join
      check("R9 no ack send during transmit", n_ack, 0);
      check("R6 result after trigger noise", res, 0);

      // R8: unslotted acknowledgement
      @(negedge clk);
      ctrl_byte = 8'h00; ack_req = 1'b1;
      @(negedge clk);
      ack_req = 1'b0;
      check("R8 ack send next cycle", int'(ack_send), 1);
      check("R8 no wait", int'(wait_trig), 0);
      @(negedge clk);
      check("R8 done", int'(done), 1);
      check("R8 result", int'(result), 0);
      @(negedge clk);

      // R7 R1: slotted acknowledgement waits for trigger
      n_ack = 0;
      ctrl_byte = 8'hF1; ack_req = 1'b1;
      @(negedge clk);
      ack_req = 1'b0;
      repeat (10) @(negedge clk);
      check("R7 waiting flag", int'(wait_trig), 1);
      check("R7 waiting status", int'(result), 1);
      check("R7 busy while waiting", int'(busy), 1);
      check("R7 no ack before trigger", n_ack, 0);
      trig_in = 1'b1;
      seen = 0;
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk);
         if (ack_send) begin seen = k; break; end
      end
      check("R7 ack send after edge", seen, 3);
      @(negedge clk);
      check("R7 done", int'(done), 1);
      check("R7 final result", int'(result), 0);
      trig_in = 1'b0;
      repeat (4) @(negedge clk);
      check("R7 back to idle", int'(busy), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule